// File: doc/BRIEF.md
# Serial Subcarrier-Lock Frame Receiver

This block takes the one-wire lock stream that a video decoder sends once per line and turns it into parallel words. A frame opens with a high-to-low transition on the serial line. After that, the block reads one data bit for every two clock cycles until it has a fixed 67-bit frame. It then loads the subcarrier frequency increment, the subcarrier phase, the sequence flag and the oscillator reset request into output registers, and raises a one-cycle strobe.

The receiver runs only while the two-bit lock-mode field from the mode register holds binary 11. In any other mode it never starts a frame. If the mode leaves 11 partway through a frame, the frame is dropped. Downstream logic samples the fields on the strobe, or at any later point until the next frame completes.

Top module: `sfl_lock_rx`

## Requirements
- R1: During synchronous active-low reset and after its release, `frame_valid` is 0 and `freq_inc`, `sc_phase`, `seq_flag` and `osc_reset_req` are all 0.
- R2: A frame starts at the clock edge where the receiver is idle, `lock_mode` is 2'b11, the line was sampled high at the previous edge and is sampled low at this edge. A line that is low from reset onward starts nothing.
- R3: Frame bit k (k = 0..66) is the line value at the second clock edge after start edge + 2k. `frame_valid` is high only in the cycle after start edge + 134, and is low in every earlier cycle of the frame.
- R4: Frame bits 0..21 form `freq_inc`, least significant bit first: frame bit 0 becomes `freq_inc[0]`.
- R5: Frame bits 22..35 form `sc_phase`, with bit 22 becoming `sc_phase[0]`. Bit 36 is `seq_flag` and bit 37 is `osc_reset_req`. Bits 38..66 are reserved and affect no output.
- R6: `frame_valid` lasts exactly one cycle. All output fields change only in that cycle and hold their values until the next completed frame.
- R7: Falling edges on the line while a frame is being received do not restart or shorten it.
- R8: When `lock_mode` is not 2'b11, no frame starts and any frame in progress is abandoned with no strobe, and the outputs keep their previous values.
- R9: The receiver is idle again in the cycle that carries the strobe, so a falling edge two cycles after the last sampling edge starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_mode | input | 2 | Lock-mode field; 2'b11 enables reception |
| sfl_line | input | 1 | Serial lock stream from the decoder |
| frame_valid | output | 1 | One-cycle strobe when a frame is complete |
| freq_inc | output | 22 | Subcarrier frequency increment |
| sc_phase | output | 14 | Subcarrier phase |
| seq_flag | output | 1 | Sequence flag (line inversion) |
| osc_reset_req | output | 1 | Request to reset the subcarrier oscillator |

## Verification
The frames sent use walking-one and alternating payloads. A walking-one value tells a bit-order reversal apart from an off-by-one field boundary. Reserved bits are filled with alternating ones and zeros, which puts falling edges inside the frame; a receiver that restarts on them misses the strobe at the expected cycle. Other runs change the mode field before a frame and partway through one, hold the line low out of reset, and send back-to-back frames. These show whether the start condition and the abort path are gated correctly and whether the receiver returns to idle in time.

// File: rtl/sfl_rx_pkg.sv
// Package: shared constants and types for the serial lock frame receiver.
// Assumes a single clock domain; sizes here are the defaults of the top.
package sfl_rx_pkg;
    localparam int unsigned DEF_FRAME_BITS = 67;
    localparam int unsigned DEF_CYC_PER_BIT = 2;
    localparam int unsigned DEF_INC_W = 22;
    localparam int unsigned DEF_PHASE_W = 14;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RECV = 1'b1
    } rx_state_e;
endpackage

// File: rtl/sfl_edge_detect.sv
// Module: registers the serial line and flags a high-to-low step.
// Assumes the line is already synchronous to clk. The registered copy
// resets low, so a line that is low out of reset never flags a step.
module sfl_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic fall_seen
);
    logic line_q;

    // Keep the previous sample of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_in;
    end

    // A step is a high previous sample followed by a low current one.
    always_comb fall_seen = line_q & ~line_in;
endmodule

// File: rtl/sfl_bit_timer.sv
// Module: frame sequencer. Starts on a qualified falling edge, divides
// the clock into bit periods and issues a sample strobe on the last
// clock of each period and a final strobe on the last frame bit.
// Assumes run_en is held for the whole frame; dropping it aborts.
module sfl_bit_timer
    import sfl_rx_pkg::*;
#(
    parameter int unsigned FRAME_BITS  = DEF_FRAME_BITS,
    parameter int unsigned CYC_PER_BIT = DEF_CYC_PER_BIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic start,
    output logic busy,
    output logic sample_stb,
    output logic last_stb
);
    localparam int unsigned IDX_W = $clog2(FRAME_BITS);
    localparam int unsigned PH_W  = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(CYC_PER_BIT - 1);

    rx_state_e        state_q;
    logic [IDX_W-1:0] idx_q;
    logic [PH_W-1:0]  ph_q;

    // Strobes decoded from the current period position.
    always_comb begin
        sample_stb = (state_q == RX_RECV) && run_en && (ph_q == LAST_PH);
        last_stb   = sample_stb && (idx_q == LAST_IDX);
        busy       = (state_q == RX_RECV);
    end

    // Sequencer state, period phase and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            idx_q   <= '0;
            ph_q    <= '0;
        end else begin
            case (state_q)
                RX_IDLE: begin
                    if (run_en && start) begin
                        state_q <= RX_RECV;
                        idx_q   <= '0;
                        ph_q    <= '0;
                    end
                end
                default: begin
                    if (!run_en) begin
                        state_q <= RX_IDLE;
                    end else if (ph_q == LAST_PH) begin
                        ph_q  <= '0;
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == LAST_IDX) state_q <= RX_IDLE;
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sfl_frame_shift.sv
// Module: collects frame bits least significant first. Each sampled bit
// enters at the top and the register shifts down, so after a full frame
// bit k sits at position k. frame_next shows the contents including the
// bit being sampled this cycle.
module sfl_frame_shift
    import sfl_rx_pkg::*;
#(
    parameter int unsigned FRAME_BITS = DEF_FRAME_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic                  bit_in,
    output logic [FRAME_BITS-1:0] frame_next
);
    logic [FRAME_BITS-1:0] sh_q;

    // Value after the current shift.
    always_comb frame_next = {bit_in, sh_q[FRAME_BITS-1:1]};

    // Shift on each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        sh_q <= '0;
        else if (shift_en) sh_q <= frame_next;
    end
endmodule

// File: rtl/sfl_lock_rx.sv
// Module: top of the serial lock frame receiver. Detects the frame start,
// times the bits and loads the decoded fields on the final bit.
// Assumes a line synchronous to clk and a mode field that is static
// apart from deliberate changes.
module sfl_lock_rx
    import sfl_rx_pkg::*;
#(
    parameter int unsigned FRAME_BITS  = DEF_FRAME_BITS,
    parameter int unsigned CYC_PER_BIT = DEF_CYC_PER_BIT,
    parameter int unsigned INC_W       = DEF_INC_W,
    parameter int unsigned PHASE_W     = DEF_PHASE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         lock_mode,
    input  logic               sfl_line,
    output logic               frame_valid,
    output logic [INC_W-1:0]   freq_inc,
    output logic [PHASE_W-1:0] sc_phase,
    output logic               seq_flag,
    output logic               osc_reset_req
);
    localparam int unsigned PH_LSB  = INC_W;
    localparam int unsigned SEQ_POS = INC_W + PHASE_W;
    localparam int unsigned RST_POS = SEQ_POS + 1;

    logic                  run_en;
    logic                  fall_seen;
    logic                  busy;
    logic                  sample_stb;
    logic                  last_stb;
    logic [FRAME_BITS-1:0] frame_next;

    // Reception is allowed only in the lock mode.
    always_comb run_en = (lock_mode == 2'b11);

    sfl_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (sfl_line),
        .fall_seen(fall_seen)
    );

    sfl_bit_timer #(
        .FRAME_BITS (FRAME_BITS),
        .CYC_PER_BIT(CYC_PER_BIT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .start     (fall_seen),
        .busy      (busy),
        .sample_stb(sample_stb),
        .last_stb  (last_stb)
    );

    sfl_frame_shift #(
        .FRAME_BITS(FRAME_BITS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (sample_stb),
        .bit_in    (sfl_line),
        .frame_next(frame_next)
    );

    // Load the decoded fields and raise the strobe on the final bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_valid   <= 1'b0;
            freq_inc      <= '0;
            sc_phase      <= '0;
            seq_flag      <= 1'b0;
            osc_reset_req <= 1'b0;
        end else begin
            frame_valid <= last_stb;
            if (last_stb) begin
                freq_inc      <= frame_next[INC_W-1:0];
                sc_phase      <= frame_next[PH_LSB +: PHASE_W];
                seq_flag      <= frame_next[SEQ_POS];
                osc_reset_req <= frame_next[RST_POS];
            end
        end
    end
endmodule

// File: rtl/sfl_lock_rx_chk.sv
// Checker: temporal properties of the receiver, bound to the top.
module sfl_lock_rx_chk #(
    parameter int unsigned FRAME_BITS  = 67,
    parameter int unsigned CYC_PER_BIT = 2,
    parameter int unsigned INC_W       = 22,
    parameter int unsigned PHASE_W     = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         lock_mode,
    input logic               frame_valid,
    input logic [INC_W-1:0]   freq_inc,
    input logic [PHASE_W-1:0] sc_phase,
    input logic               seq_flag,
    input logic               osc_reset_req,
    input logic               busy
);
    localparam int unsigned FRAME_CYC = FRAME_BITS * CYC_PER_BIT;
    localparam int unsigned RUN_W = $clog2(FRAME_CYC + 2);

    logic [RUN_W-1:0] run_q;

    // Length of the current or just-finished busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    a_r3_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (run_q == RUN_W'(FRAME_CYC)));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(freq_inc) && $stable(sc_phase)
                          && $stable(seq_flag) && $stable(osc_reset_req)));

    a_r8_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_mode != 2'b11) |=> !frame_valid);

    a_r8_no_busy_off_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_mode != 2'b11) |=> !busy);
endmodule

bind sfl_lock_rx sfl_lock_rx_chk #(
    .FRAME_BITS (FRAME_BITS),
    .CYC_PER_BIT(CYC_PER_BIT),
    .INC_W      (INC_W),
    .PHASE_W    (PHASE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_mode    (lock_mode),
    .frame_valid  (frame_valid),
    .freq_inc     (freq_inc),
    .sc_phase     (sc_phase),
    .seq_flag     (seq_flag),
    .osc_reset_req(osc_reset_req),
    .busy         (busy)
);

// File: tb/sfl_lock_rx_tb.sv
module sfl_lock_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  lock_mode = 2'b11;
    logic        sfl_line = 1'b0;
    logic        frame_valid;
    logic [21:0] freq_inc;
    logic [13:0] sc_phase;
    logic        seq_flag;
    logic        osc_reset_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sfl_lock_rx u_dut (
        .clk(clk), .rst_n(rst_n), .lock_mode(lock_mode), .sfl_line(sfl_line),
        .frame_valid(frame_valid), .freq_inc(freq_inc), .sc_phase(sc_phase),
        .seq_flag(seq_flag), .osc_reset_req(osc_reset_req)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_fields(input string req, input logic [21:0] inc,
                                input logic [13:0] ph, input logic sq, input logic rr);
        check({req, " freq_inc"}, 64'(freq_inc), 64'(inc));
        check({req, " sc_phase"}, 64'(sc_phase), 64'(ph));
        check({req, " seq_flag"}, 64'(seq_flag), 64'(sq));
        check({req, " osc_reset_req"}, 64'(osc_reset_req), 64'(rr));
    endtask

    // Start marker then 67 bits of two cycles each; ends at the negedge of
    // the strobe cycle. early counts cycles in which the strobe came too soon.
    task automatic send_frame(input logic [21:0] inc, input logic [13:0] ph,
                              input logic sq, input logic rr, input logic [28:0] resv,
                              output int early);
        logic [66:0] fr;
        fr = {resv, rr, sq, ph, inc};
        early = 0;
        sfl_line = 1'b1;
        @(negedge clk);
        sfl_line = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 67; k++) begin
            sfl_line = fr[k];
            for (int c = 0; c < 2; c++) begin
                if (frame_valid) early++;
                @(negedge clk);
            end
        end
    endtask

    task automatic t_reset;
        check("R1 valid", 64'(frame_valid), 64'd0);
        check_fields("R1", '0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_low_from_reset;
        bit seen = 1'b0;
        sfl_line = 1'b0;
        for (int i = 0; i < 160; i++) begin
            @(negedge clk);
            if (frame_valid) seen = 1'b1;
        end
        check("R2 low line no start", 64'(seen), 64'd0);
    endtask

    task automatic t_frame(input string req, input logic [21:0] inc, input logic [13:0] ph,
                           input logic sq, input logic rr, input logic [28:0] resv);
        int early;
        send_frame(inc, ph, sq, rr, resv, early);
        check({req, " R3 no early strobe"}, 64'(early), 64'd0);
        check({req, " R3 strobe at 134"}, 64'(frame_valid), 64'd1);
        check_fields({req, " R4/R5"}, inc, ph, sq, rr);
        @(negedge clk);
        check({req, " R6 strobe ends"}, 64'(frame_valid), 64'd0);
        check_fields({req, " R6 hold"}, inc, ph, sq, rr);
    endtask

    task automatic t_back_to_back;
        int early;
        send_frame(22'h2AAAAA, 14'h1555, 1'b0, 1'b1, 29'h0, early);
        check("R9 first strobe", 64'(frame_valid), 64'd1);
        send_frame(22'h000001, 14'h2000, 1'b1, 1'b0, 29'h1FFFFFFF, early);
        check("R9 second strobe", 64'(frame_valid), 64'd1);
        check_fields("R9", 22'h000001, 14'h2000, 1'b1, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_mode_off;
        int early;
        bit seen = 1'b0;
        lock_mode = 2'b01;
        send_frame(22'h3FFFFF, 14'h3FFF, 1'b0, 1'b0, 29'h0, early);
        for (int i = 0; i < 4; i++) begin
            if (frame_valid) seen = 1'b1;
            @(negedge clk);
        end
        check("R8 off mode no strobe", 64'(early + 32'(seen) + 32'(frame_valid)), 64'd0);
        check_fields("R8 off mode hold", 22'h000001, 14'h2000, 1'b1, 1'b0);
        lock_mode = 2'b11;
    endtask

    task automatic t_abort;
        bit seen = 1'b0;
        sfl_line = 1'b1;
        @(negedge clk);
        sfl_line = 1'b0;
        for (int i = 0; i < 40; i++) @(negedge clk);
        lock_mode = 2'b10;
        @(negedge clk);
        lock_mode = 2'b11;
        sfl_line = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (frame_valid) seen = 1'b1;
            @(negedge clk);
        end
        check("R8 abort no strobe", 64'(seen), 64'd0);
        check_fields("R8 abort hold", 22'h000001, 14'h2000, 1'b1, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_low_from_reset();
        // walking one in the increment and phase; quiet reserved bits
        t_frame("R4 walk", 22'h000001, 14'h0001, 1'b0, 1'b0, 29'h0);
        t_frame("R4 top", 22'h200000, 14'h2000, 1'b1, 1'b1, 29'h0);
        // alternating reserved bits give falling edges mid-frame (R7)
        t_frame("R7 edges", 22'h15A5C3, 14'h0F0F, 1'b1, 1'b0, 29'h0AAAAAAA);
        t_frame("R5 resv ones", 22'h0, 14'h0, 1'b0, 1'b1, 29'h1FFFFFFF);
        t_back_to_back();
        t_mode_off();
        t_abort();
        t_frame("R2 after abort", 22'h123456, 14'h0ABC, 1'b0, 1'b1, 29'h15555555);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule